// File: doc/BRIEF.md
# NAND Flash Page-Program Sequencer

This block walks a NAND flash device through a page-program transaction by running a short list of operation codes. The list and the command bytes are loaded, not wired in. When `start` arrives while idle, the block latches the whole configuration. That covers three command bytes, a column address, a block index and a page index, a byte count, a ready timeout and up to eight 3-bit opcodes. It then runs the slots in order on an 8-bit flash bus, using the command-latch, address-latch, write-enable and read-enable strobes.

Write data comes from a local buffer RAM that is split into two page-sized halves. The host fills it through a simple write port. The lowest bit of the page index chooses which half is sent. The ready/busy line passes through a two-flop synchronizer. A wait step gives up with an error flag if ready does not return within the programmed limit. A read-status step captures the flash's answer in the `status` byte. A one-bit ECC enable marks full-page data transfers for a neighbouring ECC block.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset: `fl_cle`=0, `fl_ale`=0, `fl_we_n`=1, `fl_re_n`=1, `busy`=0, `done`=0, `err_tmo`=0, `ecc_en`=0, `status`=0.
- R2: Slot i sits in `op_list[3i+2:3i]`, and slots run from slot 0 upward. The opcode values are 0 no-op, 1 send cmd0, 2 send cmd2, 3 column address, 4 page address, 5 buffer data, 6 wait-ready-then-cmd1, 7 read status.
- R3: A command opcode drives its command byte in one write cycle, with `fl_cle`=1 and `fl_ale`=0.
- R4: The column address goes out in two write cycles, low byte first. The page address goes out in three write cycles, low byte first, from the 24-bit row {zeros, block index, page index[5:0]}. Every address cycle has `fl_ale`=1 and `fl_cle`=0.
- R5: Each written byte holds `fl_we_n` low for at least two clocks. `fl_dq_o`, `fl_cle` and `fl_ale` stay unchanged in the clock where `fl_we_n` returns high.
- R6: The buffer-data opcode sends bytes j = 0..N-1 from buffer address h*2112+j, where h = page index bit 0. N = `byte_cnt`, and `byte_cnt`=0 means 2112 bytes.
- R7: `ecc_en` is 1 during every data write of a full-page (`byte_cnt`=0) transfer and 0 during a partial transfer.
- R8: The wait opcode issues the cmd1 byte only after the synchronized ready line is high.
- R9: If ready stays low for `tmo_lim` clocks in the wait step, `err_tmo` is set, the run ends with `done`, and cmd1 is not issued.
- R10: Read status holds `fl_re_n` low for two clocks and stores `fl_dq_i` into `status` as it releases it.
- R11: A no-op slot, or the end of the eight slots, ends the run. `busy` falls and `done` pulses for exactly one clock.
- R12: A `start` pulse while `busy` is ignored: no second run follows.
- R13: The host writes buffer bytes via `buf_we`/`buf_addr`/`buf_wdata`, one byte per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and begin a run |
| cmd0 | input | 8 | First command byte |
| cmd1 | input | 8 | Command byte sent after ready |
| cmd2 | input | 8 | Second command byte |
| op_list | input | 24 | Eight 3-bit opcodes, slot 0 lowest |
| col_addr | input | 16 | Column address |
| blk_idx | input | 10 | Erase-block index |
| page_idx | input | 6 | Page within block |
| byte_cnt | input | 12 | Data byte count, 0 = full page |
| tmo_lim | input | 16 | Ready wait limit in clocks |
| buf_we | input | 1 | Buffer write enable |
| buf_addr | input | 13 | Buffer write address |
| buf_wdata | input | 8 | Buffer write data |
| fl_rb | input | 1 | Flash ready (1) / busy (0) |
| fl_dq_i | input | 8 | Flash data in |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| ecc_en | output | 1 | Full-page ECC generation enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| err_tmo | output | 1 | Ready timeout occurred |
| status | output | 8 | Captured status byte |

## Verification
The bench targets the full 2112-byte transfer from the odd buffer half. A design with an off-by-one prefetch or a wrong half offset would send shifted or wrong bytes, or one byte too many or too few. Byte order is also checked on both address steps, since a swapped order latches the wrong page. The ready wait is tested in both outcomes. A design that skips the synchronizer guard would issue cmd1 while the flash is still busy, and a broken timeout would hang the run. Early termination by a no-op and a start pulse during a run are also covered, because either mistake would put extra strobes on the bus.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_CM0 = 3'd1,
    OP_CM2 = 3'd2,
    OP_CA  = 3'd3,
    OP_PA  = 3'd4,
    OP_WB  = 3'd5,
    OP_CW1 = 3'd6,
    OP_RS  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_BYTE, S_WAIT, S_READ, S_END
  } st_e;
endpackage

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 4224,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end
  assign q = sr[STAGES-1];
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_OPS    = 8,
  parameter int PAGE_BYTES = 2112,
  parameter int BLK_W      = 10,
  parameter int PG_W       = 6,
  parameter int TMO_W      = 16,
  parameter int WB_GUARD   = 4,
  localparam int OPS_W     = 3 * NUM_OPS,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
  localparam int BUF_DEPTH = 2 * PAGE_BYTES,
  localparam int BUF_AW    = $clog2(BUF_DEPTH),
  localparam int SLOT_W    = $clog2(NUM_OPS + 1),
  localparam int ROW_W     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        cmd0,
  input  logic [7:0]        cmd1,
  input  logic [7:0]        cmd2,
  input  logic [OPS_W-1:0]  op_list,
  input  logic [15:0]       col_addr,
  input  logic [BLK_W-1:0]  blk_idx,
  input  logic [PG_W-1:0]   page_idx,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [TMO_W-1:0]  tmo_lim,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  input  logic              fl_rb,
  input  logic [7:0]        fl_dq_i,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic              ecc_en,
  output logic              busy,
  output logic              done,
  output logic              err_tmo,
  output logic [7:0]        status
);
  st_e              st;
  op_e              op;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0] k, n;
  logic [1:0]       ph;
  logic [TMO_W-1:0] wcnt;
  logic [7:0]       c_cmd0, c_cmd1, c_cmd2;
  logic [OPS_W-1:0] c_ops;
  logic [15:0]      c_col;
  logic [ROW_W-1:0] c_row;
  logic             c_half, c_full;
  logic [CNT_W-1:0] c_n_wb;
  logic [TMO_W-1:0] c_tmo;

  logic             rb_s;
  logic [7:0]       rdata;
  logic [BUF_AW-1:0] raddr, roff;
  logic [OPS_W-1:0] ops_sh;
  op_e              fetched;
  logic [15:0]      col_sh;
  logic [ROW_W-1:0] row_sh;
  logic [7:0]       bval;
  logic             bcle, bale;

  nand_rb_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(fl_rb), .q(rb_s)
  );

  // buffer read address: prefetch byte 0 during FETCH, byte k while streaming
  assign roff  = (st == S_BYTE && k < CNT_W'(PAGE_BYTES)) ? BUF_AW'(k) : '0;
  assign raddr = c_half ? BUF_AW'(PAGE_BYTES) + roff : roff;

  nand_page_buf #(.DW(8), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign ops_sh  = c_ops >> (3 * slot);
  assign fetched = op_e'(ops_sh[2:0]);
  assign col_sh  = c_col >> {k[0], 3'b000};
  assign row_sh  = c_row >> {k[1:0], 3'b000};

  always_comb begin
    bval = 8'h00;
    bcle = 1'b0;
    bale = 1'b0;
    case (op)
      OP_CM0: begin bval = c_cmd0;      bcle = 1'b1; end
      OP_CM2: begin bval = c_cmd2;      bcle = 1'b1; end
      OP_CW1: begin bval = c_cmd1;      bcle = 1'b1; end
      OP_CA:  begin bval = col_sh[7:0]; bale = 1'b1; end
      OP_PA:  begin bval = row_sh[7:0]; bale = 1'b1; end
      OP_WB:  bval = rdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; op <= OP_NOP; slot <= '0; k <= '0; n <= '0; ph <= '0;
      wcnt <= '0; c_cmd0 <= '0; c_cmd1 <= '0; c_cmd2 <= '0; c_ops <= '0;
      c_col <= '0; c_row <= '0; c_half <= 1'b0; c_full <= 1'b0;
      c_n_wb <= '0; c_tmo <= '0;
      fl_dq_o <= '0; fl_dq_oe <= 1'b0; fl_cle <= 1'b0; fl_ale <= 1'b0;
      fl_we_n <= 1'b1; fl_re_n <= 1'b1; ecc_en <= 1'b0;
      busy <= 1'b0; done <= 1'b0; err_tmo <= 1'b0; status <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            c_cmd0 <= cmd0; c_cmd1 <= cmd1; c_cmd2 <= cmd2; c_ops <= op_list;
            c_col  <= col_addr;
            c_row  <= ROW_W'({blk_idx, page_idx});
            c_half <= page_idx[0];
            c_full <= (byte_cnt == '0);
            c_n_wb <= (byte_cnt == '0) ? CNT_W'(PAGE_BYTES) : byte_cnt;
            c_tmo  <= tmo_lim;
            slot <= '0; err_tmo <= 1'b0; busy <= 1'b1;
            st <= S_FETCH;
          end
        end
        S_FETCH: begin
          k  <= '0;
          op <= fetched;
          ecc_en <= (fetched == OP_WB) && c_full;
          if (slot == SLOT_W'(NUM_OPS)) begin
            st <= S_END;
          end else begin
            slot <= slot + 1'b1;
            case (fetched)
              OP_NOP: st <= S_END;
              OP_CM0, OP_CM2: begin n <= CNT_W'(1); st <= S_LOAD; end
              OP_CA:  begin n <= CNT_W'(2); st <= S_LOAD; end
              OP_PA:  begin n <= CNT_W'(3); st <= S_LOAD; end
              OP_WB:  begin n <= c_n_wb;    st <= S_LOAD; end
              OP_CW1: begin wcnt <= '0;     st <= S_WAIT; end
              default: begin fl_re_n <= 1'b0; ph <= '0; st <= S_READ; end
            endcase
          end
        end
        S_LOAD: begin
          fl_dq_o <= bval; fl_cle <= bcle; fl_ale <= bale;
          fl_we_n <= 1'b0; fl_dq_oe <= 1'b1; ph <= '0;
          st <= S_BYTE;
        end
        S_BYTE: begin
          case (ph)
            2'd0: begin k <= k + 1'b1; ph <= 2'd1; end
            2'd1: begin fl_we_n <= 1'b1; ph <= 2'd2; end
            default: begin
              if (k == n) begin
                fl_cle <= 1'b0; fl_ale <= 1'b0; fl_dq_oe <= 1'b0;
                st <= S_FETCH;
              end else begin
                fl_dq_o <= bval; fl_cle <= bcle; fl_ale <= bale;
                fl_we_n <= 1'b0; ph <= 2'd0;
              end
            end
          endcase
        end
        S_WAIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt >= TMO_W'(WB_GUARD) && rb_s) begin
            n <= CNT_W'(1); k <= '0;
            st <= S_LOAD;
          end else if (wcnt >= c_tmo) begin
            err_tmo <= 1'b1;
            st <= S_END;
          end
        end
        S_READ: begin
          if (ph == 2'd0) begin
            ph <= 2'd1;
          end else begin
            status  <= fl_dq_i;
            fl_re_n <= 1'b1;
            st <= S_FETCH;
          end
        end
        default: begin
          busy <= 1'b0; done <= 1'b1; ecc_en <= 1'b0;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] fl_dq_o,
  input logic       fl_cle,
  input logic       fl_ale,
  input logic       fl_we_n,
  input logic       fl_re_n,
  input logic       ecc_en,
  input logic       busy,
  input logic       done,
  input logic       err_tmo
);
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst) !(fl_cle && fl_ale)); // R4
  AST_WE_MIN_LOW: assert property (@(posedge clk) disable iff (rst) $fell(fl_we_n) |=> !fl_we_n); // R5
  AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> ($stable(fl_dq_o) && $stable(fl_cle) && $stable(fl_ale))); // R5
  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst) !(!fl_we_n && !fl_re_n)); // R10
  AST_RE_TWO: assert property (@(posedge clk) disable iff (rst) $fell(fl_re_n) |=> !fl_re_n); // R10
  AST_ECC_DATA_ONLY: assert property (@(posedge clk) disable iff (rst) ecc_en |-> (!fl_cle && !fl_ale)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (fl_we_n && fl_re_n)); // R11
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (rst) $rose(err_tmo) |=> !busy); // R9
endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (
  .clk(clk), .rst(rst), .fl_dq_o(fl_dq_o), .fl_cle(fl_cle), .fl_ale(fl_ale),
  .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .ecc_en(ecc_en), .busy(busy),
  .done(done), .err_tmo(err_tmo)
);

// File: tb/nand_prog_seq_tb.sv
module nand_prog_seq_tb;
  localparam int PB = 2112;
  localparam logic [23:0] STD_OPS = {3'd0, 3'd7, 3'd6, 3'd2, 3'd5, 3'd4, 3'd3, 3'd1};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] cmd0 = 8'h80, cmd1 = 8'h70, cmd2 = 8'h10;
  logic [23:0] op_list = STD_OPS;
  logic [15:0] col_addr = '0;
  logic [9:0] blk_idx = '0;
  logic [5:0] page_idx = '0;
  logic [11:0] byte_cnt = '0;
  logic [15:0] tmo_lim = 16'd500;
  logic buf_we = 1'b0;
  logic [12:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic fl_rb;
  logic [7:0] fl_dq_i, fl_dq_o, status, stat_val = 8'hE0;
  logic fl_dq_oe, fl_cle, fl_ale, fl_we_n, fl_re_n, ecc_en, busy, done, err_tmo;

  int checks = 0, fails = 0;
  int busy_len = 40;

  always #4 clk = ~clk;

  nand_prog_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd0(cmd0), .cmd1(cmd1), .cmd2(cmd2),
    .op_list(op_list), .col_addr(col_addr), .blk_idx(blk_idx), .page_idx(page_idx),
    .byte_cnt(byte_cnt), .tmo_lim(tmo_lim), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .fl_rb(fl_rb), .fl_dq_i(fl_dq_i), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
    .fl_re_n(fl_re_n), .ecc_en(ecc_en), .busy(busy), .done(done),
    .err_tmo(err_tmo), .status(status)
  );

  // flash model and bus monitor
  logic [10:0] lg [0:4095];
  int nlog = 0, rb_cnt = 0, low_run = 0, hold_bad = 0, short_low = 0;
  int early_c1 = 0, done_wide = 0;
  logic prev_we = 1'b1, prev_done = 1'b0;
  logic [7:0] prev_dq = '0;

  assign fl_rb   = (rb_cnt == 0);
  assign fl_dq_i = fl_re_n ? 8'h00 : stat_val;

  always @(posedge clk) begin
    prev_we <= fl_we_n; prev_dq <= fl_dq_o; prev_done <= done;
    low_run <= fl_we_n ? 0 : low_run + 1;
    if (done && prev_done) done_wide <= done_wide + 1;
    if (!prev_we && fl_we_n) begin
      if (fl_dq_o != prev_dq) hold_bad <= hold_bad + 1;
      if (low_run < 2) short_low <= short_low + 1;
      if (nlog < 4096) lg[nlog] <= {fl_cle, fl_ale, ecc_en, fl_dq_o};
      nlog <= nlog + 1;
      if (fl_cle && fl_dq_o == cmd1 && !fl_rb) early_c1 <= early_c1 + 1;
      if (fl_cle && fl_dq_o == cmd2) rb_cnt <= busy_len;
      else if (rb_cnt != 0) rb_cnt <= rb_cnt - 1;
    end else if (rb_cnt != 0) rb_cnt <= rb_cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int h, input int j);
    return 8'(j * 7 + h * 91 + 3) ^ 8'(j >> 8);
  endfunction

  task automatic fill(input int h, input int cnt);
    for (int j = 0; j < cnt; j++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = 13'(h * PB + j); buf_wdata = pat(h, j);
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic run_and_wait(output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
  endtask

  // compare one logged write: cle, ale, data
  task automatic chk_ent(input int idx, input bit c, input bit a, input logic [7:0] d, input string req);
    chk(lg[idx][10] == c && lg[idx][9] == a && lg[idx][7:0] == d, req,
        int'(lg[idx]), int'({c, a, 1'b0, d}));
  endtask

  task automatic t_reset;
    chk(!fl_cle && !fl_ale && fl_we_n && fl_re_n, "R1 strobes", int'({fl_cle, fl_ale, fl_we_n, fl_re_n}), 3);
    chk(!busy && !done && !err_tmo && !ecc_en && status == 8'h00, "R1 flags",
        int'({busy, done, err_tmo, ecc_en, status}), 0);
  endtask

  task automatic t_full_page;
    int base, cyc, bad, eccbad, hb, sl;
    logic [23:0] row;
    fill(1, PB);                                 // R13 host buffer load
    base = nlog; hb = hold_bad; sl = short_low;
    col_addr = 16'h0123; blk_idx = 10'h2AB; page_idx = 6'd5; byte_cnt = 12'd0;
    op_list = STD_OPS; busy_len = 40; stat_val = 8'hE0;
    row = {8'h00, blk_idx, page_idx};
    run_and_wait(cyc);
    @(negedge clk);
    chk(nlog - base == 2120, "R2 R6 write count", nlog - base, 2120);
    chk_ent(base + 0, 1, 0, 8'h80, "R3 cmd0");
    chk_ent(base + 1, 0, 1, 8'h23, "R4 col lo");
    chk_ent(base + 2, 0, 1, 8'h01, "R4 col hi");
    chk_ent(base + 3, 0, 1, row[7:0], "R4 row0");
    chk_ent(base + 4, 0, 1, row[15:8], "R4 row1");
    chk_ent(base + 5, 0, 1, row[23:16], "R4 row2");
    bad = 0; eccbad = 0;
    for (int j = 0; j < PB; j++) begin
      if (lg[base + 6 + j][10:9] != 2'b00 || lg[base + 6 + j][7:0] != pat(1, j)) bad++;
      if (!lg[base + 6 + j][8]) eccbad++;
    end
    chk(bad == 0, "R6 odd-half page data", bad, 0);
    chk(eccbad == 0, "R7 ecc on full page", eccbad, 0);
    chk_ent(base + 2118, 1, 0, 8'h10, "R3 cmd2");
    chk_ent(base + 2119, 1, 0, 8'h70, "R8 cmd1 after ready");
    chk(early_c1 == 0, "R8 cmd1 not while busy", early_c1, 0);
    chk(hold_bad == hb && short_low == sl, "R5 strobe timing", hold_bad - hb + short_low - sl, 0);
    chk(status == 8'hE0, "R10 status capture", status, 8'hE0);
    chk(!busy && !err_tmo && done_wide == 0, "R11 finish", int'({busy, err_tmo}), 0);
  endtask

  task automatic t_partial_and_restart;
    int base, cyc, bad;
    fill(0, 8);
    base = nlog;
    col_addr = 16'h0000; blk_idx = 10'h001; page_idx = 6'd2; byte_cnt = 12'd5;
    busy_len = 300; stat_val = 8'hC1; tmo_lim = 16'd2000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    op_list = {8{3'd1}};
    start = 1'b1;                               // R12 start during run
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    repeat (20) @(negedge clk);
    chk(nlog - base == 13, "R12 no second run", nlog - base, 13);
    chk(!busy, "R12 stays idle", busy, 0);
    bad = 0;
    for (int j = 0; j < 5; j++)
      if (lg[base + 6 + j][7:0] != pat(0, j) || lg[base + 6 + j][8]) bad++;
    chk(bad == 0, "R6 R7 partial even-half data, ecc off", bad, 0);
    chk(status == 8'hC1, "R10 second status", status, 8'hC1);
    op_list = STD_OPS;
  endtask

  task automatic t_nop_early;
    int base, cyc;
    base = nlog;
    op_list = {3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd0, 3'd1};
    run_and_wait(cyc);
    repeat (5) @(negedge clk);
    chk(nlog - base == 1, "R11 no-op ends run", nlog - base, 1);
    chk_ent(base, 1, 0, 8'h80, "R2 slot0 first");
    op_list = STD_OPS;
  endtask

  task automatic t_timeout;
    int base, cyc;
    base = nlog;
    byte_cnt = 12'd2; busy_len = 5000; tmo_lim = 16'd100; stat_val = 8'h55;
    run_and_wait(cyc);
    repeat (3) @(negedge clk);
    chk(err_tmo == 1'b1, "R9 timeout flag", err_tmo, 1);
    chk(nlog - base == 9, "R9 no cmd1 after timeout", nlog - base, 9);
    chk(cyc < 400, "R9 run ends", cyc, 400);
    chk(status != 8'h55, "R9 no status read", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_page();
    t_partial_and_restart();
    t_nop_early();
    t_timeout();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule